// File: doc/BRIEF.md
# Triple Timer-Counter Peripheral

This peripheral holds three identical 16-bit timer-counter channels behind one word-addressed register port. Each channel counts clock steps, optionally slowed by a power-of-two prescaler, either upward or downward. It wraps either at the full 16-bit range or at a programmable interval limit. Three match comparators per channel flag the step on which the counter lands on a programmed value. All of these events collect in a status register that clears when it is read. A six-bit enable mask selects which status bits drive that channel's level interrupt line.

The register file is interleaved. Every register kind takes three consecutive 32-bit words, one word per channel, so software reaches channel c of kind k at byte offset 4*(3k + c). Reads are combinational in the cycle the read strobe is high. Writes and the clear-on-read side effect take hold at the following clock edge. The event-control register is plain storage. The event-count word reads as zero.

Top module: `tri_timer_periph`

## Requirements
- R1: After a synchronous active-low reset, each channel's counter control reads 0x21, so the channel is disabled. Counter value, interval, matches, status, interrupt enable, event control and clock control all read 0, and every irq bit is low.
- R2: With word index w = offset >> 2, kind = w / 3 and channel = w mod 3. Kinds in order are: 0 clock control, 1 counter control, 2 counter value, 3 interval, 4 to 6 match 1 to 3, 7 status, 8 interrupt enable, 9 event control, 10 event count. Read data is valid in the same cycle as bus_rd. A write takes effect at the next clock edge.
- R3: An offset with nonzero bits 1:0, or above 0x80, reads 0 and is ignored on write. Writes to the counter value, status and event count words change nothing.
- R4: Clock control bit 0 enables the prescaler, and bits 4:1 hold N. With the prescaler enabled, a running counter steps once every 2^(N+1) clocks. With it off, the counter steps every clock.
- R5: Counter control fields are: bit 0 disable (the counter holds), bit 1 interval mode, bit 2 count down, bit 3 match enable. Writing bit 4 as 1 zeroes the counter and restarts the prescaler at the next edge. Bit 4 always reads back 0.
- R6: The wrap limit is the interval value in interval mode and 0xFFFF otherwise. Counting up from the limit (or above it) gives 0. Counting down from 0 gives the limit.
- R7: A wrap sets status bit 0 in interval mode and status bit 4 otherwise. Status bit 5 (event) is never set.
- R8: While match enable is set, a step that lands the counter on match i sets status bit i (1 to 3). A match value above the wrap limit never sets its bit.
- R9: A status read returns the current bits and clears them at the next edge. A bit set by an event in that same cycle survives the clear.
- R10: irq[c] is high exactly when channel c's status AND interrupt enable is nonzero. It follows the status register with no extra delay.
- R11: Stored widths are: clock control 6 bits, counter control 6 bits, interrupt enable 6 bits, event control 3 bits, interval and match 16 bits. Counter value reads return 16 bits. Unused upper write bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status reads clear) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 3 | Level interrupt, one per channel |

## Verification
Read data is due in the same cycle as bus_rd. The bench compares it one time unit after driving the strobe, before the edge at which the read's clear takes place. A counter step, status update or register write lands on the edge after it is issued, and irq follows that status register combinationally. The behavioural model therefore advances on the same edge, and the bench compares irq at every falling edge. Reads placed on consecutive cycles during interval counting make some status clears coincide with fresh wrap and match events. This exercises the same-cycle survival rule.

// File: rtl/tmr_pkg.sv
// Shared definitions for the triple timer-counter peripheral.
// Assumes three match comparators and the fixed status bit layout below.
package tmr_pkg;
    localparam int KIND_W    = 4;
    localparam int NUM_KINDS = 11;
    localparam int NUM_MATCH = 3;
    localparam int STAT_W    = NUM_MATCH + 3;   // wrap, matches, overflow, event
    localparam int CTL_W     = 6;

    // counter control bit positions
    localparam int CTL_DIS  = 0;
    localparam int CTL_INTV = 1;
    localparam int CTL_DOWN = 2;
    localparam int CTL_MEN  = 3;
    localparam int CTL_CLR  = 4;
    localparam logic [CTL_W-1:0] CTL_RESET = 6'h21;

    // status bit positions
    localparam int ST_IWRAP = 0;
    localparam int ST_OVF   = NUM_MATCH + 1;

    typedef enum logic [KIND_W-1:0] {
        K_CLK    = 4'd0,
        K_CTRL   = 4'd1,
        K_VALUE  = 4'd2,
        K_INTV   = 4'd3,
        K_MATCH1 = 4'd4,
        K_MATCH2 = 4'd5,
        K_MATCH3 = 4'd6,
        K_STAT   = 4'd7,
        K_IEN    = 4'd8,
        K_EVCTL  = 4'd9,
        K_EVCNT  = 4'd10
    } reg_kind_e;
endpackage

// File: rtl/tmr_prescale.sv
// Power-of-two step generator for one channel.
// Emits one tick every 2^(ps_val+1) clocks when ps_en is set, otherwise
// every clock; idle and reset to zero while run is low or restart pulses.
module tmr_prescale #(
    parameter int PSV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             ps_en,
    input  logic [PSV_W-1:0] ps_val,
    output logic             tick
);
    localparam int CW = (1 << PSV_W) + 1;

    logic [CW-1:0] div_q;
    logic [CW-1:0] limit;
    logic [PSV_W:0] shamt;

    // terminal count of the divider for the programmed N
    always_comb begin
        shamt = {1'b0, ps_val} + 1'b1;
        limit = ({{(CW-1){1'b0}}, 1'b1} << shamt) - 1'b1;
        tick  = run && (!ps_en || (div_q >= limit));
    end

    // divider counter: clears on a tick, on restart and while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                      div_q <= '0;
        else if (!run || restart || tick) div_q <= '0;
        else                             div_q <= div_q + 1'b1;
    end

    // R4: with the prescaler on, two ticks are never adjacent
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && ps_en |=> !(tick && ps_en));
endmodule

// File: rtl/tmr_channel.sv
// One timer-counter channel: configuration storage, counter, three match
// comparators, clear-on-read status and its interrupt line.
// Assumes wr_en/rd_en are already qualified for this channel and mapped.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int PSV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_kind_e         kind,
    input  logic [CNT_W-1:0]  wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CLKC_W = PSV_W + 2;
    localparam int EVC_W  = 3;

    logic [CLKC_W-1:0] clkc_q;
    logic [CTL_W-1:0]  ctrl_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt, top;
    logic [CNT_W-1:0]  intv_q;
    logic [CNT_W-1:0]  match_q [NUM_MATCH];
    logic [STAT_W-1:0] stat_q, evt;
    logic [STAT_W-1:0] ien_q;
    logic [EVC_W-1:0]  evc_q;
    logic              run, tick, at_edge, clr_cnt, rd_stat;

    assign run     = !ctrl_q[CTL_DIS];
    assign clr_cnt = wr_en && (kind == K_CTRL) && wdata[CTL_CLR];
    assign rd_stat = rd_en && (kind == K_STAT);

    tmr_prescale #(.PSV_W(PSV_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(clr_cnt),
        .ps_en  (clkc_q[0]),
        .ps_val (clkc_q[PSV_W:1]),
        .tick   (tick)
    );

    // wrap limit and next counter value for a step
    always_comb begin
        top = ctrl_q[CTL_INTV] ? intv_q : '1;
        if (ctrl_q[CTL_DOWN]) begin
            at_edge = (cnt_q == '0);
            cnt_nxt = at_edge ? top : cnt_q - 1'b1;
        end else begin
            at_edge = (cnt_q >= top);
            cnt_nxt = at_edge ? '0 : cnt_q + 1'b1;
        end
    end

    // wrap event bits: interval wrap or full-range overflow
    always_comb begin
        evt[ST_IWRAP]  = tick && at_edge && ctrl_q[CTL_INTV];
        evt[ST_OVF]    = tick && at_edge && !ctrl_q[CTL_INTV];
        evt[STAT_W-1]  = 1'b0;
    end

    // one comparator per match register
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        always_comb
            evt[i+1] = tick && ctrl_q[CTL_MEN] && (match_q[i] <= top)
                       && (cnt_nxt == match_q[i]);

        // match register write port
        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q[i] <= '0;
            else if (wr_en && kind == reg_kind_e'(int'(K_MATCH1) + i))
                match_q[i] <= wdata;
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkc_q <= '0;
            ctrl_q <= CTL_RESET;
            intv_q <= '0;
            ien_q  <= '0;
            evc_q  <= '0;
        end else if (wr_en) begin
            case (kind)
                K_CLK:   clkc_q <= wdata[CLKC_W-1:0];
                K_CTRL:  ctrl_q <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << CTL_CLR);
                K_INTV:  intv_q <= wdata;
                K_IEN:   ien_q  <= wdata[STAT_W-1:0];
                K_EVCTL: evc_q  <= wdata[EVC_W-1:0];
                default: ;
            endcase
        end
    end

    // counter: software clear wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_cnt) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_nxt;
    end

    // status: clear on read, same-cycle events kept
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_stat ? '0 : stat_q) | evt;
    end

    // read mux for this channel
    always_comb begin
        rdata = '0;
        case (kind)
            K_CLK:    rdata = DATA_W'(clkc_q);
            K_CTRL:   rdata = DATA_W'(ctrl_q);
            K_VALUE:  rdata = DATA_W'(cnt_q);
            K_INTV:   rdata = DATA_W'(intv_q);
            K_MATCH1: rdata = DATA_W'(match_q[0]);
            K_MATCH2: rdata = DATA_W'(match_q[1]);
            K_MATCH3: rdata = DATA_W'(match_q[2]);
            K_STAT:   rdata = DATA_W'(stat_q);
            K_IEN:    rdata = DATA_W'(ien_q);
            K_EVCTL:  rdata = DATA_W'(evc_q);
            default:  rdata = '0;
        endcase
    end

    assign irq = |(stat_q & ien_q);

    // R5: a clear write leaves the counter at zero
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> cnt_q == '0);
    // R5: a disabled channel holds its count
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr_cnt |=> $stable(cnt_q));
    // R6: counting down from zero reloads the limit
    a_r6_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && ctrl_q[CTL_DOWN] && cnt_q == '0 && !clr_cnt |=> cnt_q == $past(top));
    // R9: status bits never drop without a read
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> (stat_q & $past(stat_q)) == $past(stat_q));
    // R9: after a read only same-cycle events remain
    a_r9_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> stat_q == $past(evt));
    // R8: match 1 status rises only with match enable set
    a_r8_match_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[1] ##1 stat_q[1] |-> $past(ctrl_q[CTL_MEN]));
    // R7: the event bit is never raised
    a_r7_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[STAT_W-1]);
endmodule

// File: rtl/tri_timer_periph.sv
// Three interleaved timer-counter channels behind a word register port.
// Decodes byte offset into register kind and channel (kind-major, channel
// minor), fans strobes to the selected channel and muxes its read data.
module tri_timer_periph
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int LAST_WORD = NUM_KINDS * NUM_CH - 1;

    logic [WORD_W-1:0] word;
    logic              mapped;
    logic [KIND_W-1:0] kind_sel;
    logic [CH_W-1:0]   ch_sel;
    reg_kind_e         kind;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];

    // address decode: word index split into kind and channel
    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        mapped   = (bus_addr[1:0] == 2'b00) && (int'(word) <= LAST_WORD);
        kind_sel = KIND_W'(word / WORD_W'(NUM_CH));
        ch_sel   = CH_W'(word % WORD_W'(NUM_CH));
        kind     = reg_kind_e'(kind_sel);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PSV_W(PSV_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && mapped && ch_sel == CH_W'(c)),
            .rd_en (bus_rd && mapped && ch_sel == CH_W'(c)),
            .kind  (kind),
            .wdata (bus_wdata[CNT_W-1:0]),
            .rdata (ch_rdata[c]),
            .irq   (irq[c])
        );
    end

    // read data: selected channel, zero when unmapped
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (mapped && ch_sel == CH_W'(c)) bus_rdata = ch_rdata[c];
    end

    // R3: misaligned offsets read as zero
    a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr[1:0] != 2'b00 |-> bus_rdata == '0);
endmodule

// File: tb/tri_timer_periph_tb.sv
// Self-checking bench with a behavioural reference model compared each clock.
module tri_timer_periph_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    tri_timer_periph u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model state
    int m_clk[3], m_ctrl[3], m_cnt[3], m_intv[3], m_stat[3], m_ien[3], m_evc[3], m_ps[3];
    int m_match[3][3];

    function automatic bit is_mapped(int a);
        return (a % 4 == 0) && (a / 4 <= 32);
    endfunction

    function automatic int model_read(int a);
        int k, c;
        if (!is_mapped(a)) return 0;
        k = (a / 4) / 3;
        c = (a / 4) % 3;
        case (k)
            0: return m_clk[c];
            1: return m_ctrl[c];
            2: return m_cnt[c];
            3: return m_intv[c];
            4, 5, 6: return m_match[c][k-4];
            7: return m_stat[c];
            8: return m_ien[c];
            9: return m_evc[c];
            default: return 0;
        endcase
    endfunction

    // model advance at each rising edge, using the inputs held across it
    always @(posedge clk) begin : mdl
        int k, c, a, d, top, ev, nc, np, lim;
        bit tk, wsel, rsel;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_clk[i] = 0; m_ctrl[i] = 'h21; m_cnt[i] = 0; m_intv[i] = 0;
                m_stat[i] = 0; m_ien[i] = 0; m_evc[i] = 0; m_ps[i] = 0;
                for (int j = 0; j < 3; j++) m_match[i][j] = 0;
            end
        end else begin
            a = int'(bus_addr);
            d = int'(bus_wdata);
            k = (a / 4) / 3;
            for (int i = 0; i < 3; i++) begin
                wsel = bus_wr && is_mapped(a) && ((a / 4) % 3 == i);
                rsel = bus_rd && is_mapped(a) && ((a / 4) % 3 == i);
                c = i;
                ev = 0; tk = 0; np = 0; nc = m_cnt[c];
                top = (m_ctrl[c] & 2) ? m_intv[c] : 65535;
                if ((m_ctrl[c] & 1) == 0) begin
                    lim = (m_clk[c] & 1) ? (1 << (((m_clk[c] >> 1) & 15) + 1)) - 1 : 0;
                    tk = (m_ps[c] >= lim);
                    np = tk ? 0 : m_ps[c] + 1;
                end
                if (tk) begin
                    if (m_ctrl[c] & 4) begin
                        if (m_cnt[c] == 0) begin nc = top; ev = (m_ctrl[c] & 2) ? 1 : 16; end
                        else nc = m_cnt[c] - 1;
                    end else begin
                        if (m_cnt[c] >= top) begin nc = 0; ev = (m_ctrl[c] & 2) ? 1 : 16; end
                        else nc = m_cnt[c] + 1;
                    end
                    if (m_ctrl[c] & 8)
                        for (int j = 0; j < 3; j++)
                            if (m_match[c][j] <= top && nc == m_match[c][j]) ev |= (2 << j);
                end
                m_stat[c] = ((rsel && k == 7) ? 0 : m_stat[c]) | ev;
                if (wsel && k == 1 && (d & 16)) begin nc = 0; np = 0; end
                m_cnt[c] = nc;
                m_ps[c] = np;
                if (wsel) begin
                    case (k)
                        0: m_clk[c] = d & 'h3f;
                        1: m_ctrl[c] = d & 'h2f;
                        3: m_intv[c] = d & 'hffff;
                        4, 5, 6: m_match[c][k-4] = d & 'hffff;
                        8: m_ien[c] = d & 'h3f;
                        9: m_evc[c] = d & 7;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R10: irq compared against the model at every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 3; i++) begin
                checks++;
                if (irq[i] !== ((m_stat[i] & m_ien[i]) != 0)) begin
                    errors++;
                    $display("FAIL R10 irq[%0d] actual %0b expected %0b", i, irq[i],
                             (m_stat[i] & m_ien[i]) != 0);
                end
            end
        end
    end

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, input string req);
        int exp;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'(a);
        #1;
        exp = model_read(a);
        checks++;
        if (bus_rdata !== 32'(exp)) begin
            errors++;
            $display("FAIL %s read 0x%02h actual 0x%0h expected 0x%0h", req, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < 3; c++) begin
            bus_read('h0c + 4*c, "R1");
            bus_read('h54 + 4*c, "R1");
            bus_read('h18 + 4*c, "R1");
            bus_read('h00 + 4*c, "R1");
        end

        // R3: unmapped and read-only words
        bus_write('h84, 'h3f);
        bus_write('h01, 'h3f);
        bus_read('h84, "R3");
        bus_read('h0d, "R3");
        bus_read('hfc, "R3");
        bus_read('h00, "R3");
        bus_write('h18, 'h1234);
        bus_read('h18, "R3");
        bus_write('h78, 5);
        bus_read('h78, "R3");

        // R11: stored widths, R2: interleaved decode
        bus_write('h00, 'hffff);
        bus_read('h00, "R11");
        bus_read('h04, "R2");
        bus_write('h00, 0);
        bus_write('h6c, 'hff);
        bus_read('h6c, "R11");
        bus_read('h70, "R2");
        bus_write('h24, 'h12345);
        bus_read('h24, "R11");

        // R6 R7 R8 R9: channel 0 interval mode up, limit 7
        bus_write('h24, 7);
        bus_write('h30, 3);
        bus_write('h3c, 7);
        bus_write('h48, 9);      // above limit: never flags
        bus_write('h60, 'h0f);
        bus_write('h0c, 'h0a);
        for (int n = 0; n < 30; n++) begin
            bus_read('h18, "R6");
            bus_read('h54, "R9");
        end
        // R9: same-cycle clear and event on back-to-back status reads
        for (int n = 0; n < 20; n++) bus_read('h54, "R9");
        bus_write('h54, 'h3f);
        bus_read('h54, "R3");

        // R5: counter clear bit not stored, zeroes counter
        idle(3);
        bus_write('h0c, 'h1a);
        bus_read('h0c, "R5");
        bus_read('h18, "R5");

        // R4 R6: channel 1 down, interval 5, prescaler N=1
        bus_write('h04, 'h03);
        bus_write('h28, 5);
        bus_write('h34, 2);
        bus_write('h64, 'h3f);
        bus_write('h10, 'h0e);
        for (int n = 0; n < 30; n++) begin
            bus_read('h1c, "R4");
            bus_read('h58, "R7");
        end
        // R4: prescaler N=2 on channel 1
        bus_write('h04, 'h05);
        for (int n = 0; n < 20; n++) bus_read('h1c, "R4");

        // R6 R7 R8: channel 2 full range down, match enable off
        bus_write('h38, 'hfffe);
        bus_write('h68, 'h10);
        bus_write('h14, 'h04);
        idle(3);
        bus_read('h20, "R6");
        bus_read('h5c, "R7");
        bus_read('h5c, "R8");
        // R8: full range up with match enabled
        bus_write('h50, 'h0005);
        bus_write('h14, 'h18);
        for (int n = 0; n < 12; n++) bus_read('h5c, "R8");

        // R5: disable holds the count
        bus_write('h0c, 'h0b);
        idle(4);
        bus_read('h18, "R5");
        idle(4);
        bus_read('h18, "R5");

        idle(10);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule